// File: doc/BRIEF.md
# Programmable Reference Divider with Phase Detector and Pump-Pin Steering

This block divides a reference clock by a programmable ratio and compares the divided reference against a divided feedback pulse with a small phase-frequency detector. The detector's lead information reaches a charge-pump output modelled as three signals: an up request, a down request and an output enable. When the enable is low the pin is released (high impedance). The analog pump, the oscillator and the feedback counter are outside the block. The block runs entirely on the reference clock. The feedback pulse arrives as a single-cycle event synchronous to that clock.

Three control inputs share the pump pin between the detector and a test path. The first releases the pin and holds the detector idle. The second chooses the detector polarity: with the negative setting the up and down requests are exchanged, for oscillators whose frequency falls as control voltage rises. The third steers a raw divider output onto the pin in place of the detector. In that case the polarity input chooses which divider. Test steering is only legal while the release input is also high.

A new ratio is taken only at the divider's terminal count, so a period in progress always completes. Ratios 0 and 1 are refused: the divider keeps its last accepted ratio and reports the refusal on an error flag.

Top module: `refdiv_pfd_steer`

## Requirements
- R1: `ref_pulse` is high for exactly one clock cycle per period. For any accepted ratio N from 2 to 1023, consecutive rising edges of `ref_pulse` are exactly N cycles apart.
- R2: `ref_pulse`, `pump_up`, `pump_dn` and `ratio_err` are low in reset. The ratio after reset is DEF_RATIO (4). `ref_pulse` first rises after the third rising clock edge that follows reset release.
- R3: A `ratio` value below 2 (0 or 1) is never accepted. The divider keeps its previous accepted ratio. `ratio_err` is high in the cycle after `ratio` shows such a value, and low in the cycle after it shows a value of 2 or more.
- R4: `ratio` is sampled only on the clock edge that ends a `ref_pulse` cycle. A change made during a period does not alter that period's length.
- R5: Normal detect mode is `test_steer`=0, `pin_release`=0 and `pol_positive`=1. In this mode `pump_oe`=1. `pump_up` rises the cycle after a `ref_pulse` and `pump_dn` rises the cycle after a `fb_pulse`. A pending request clears the cycle after the other input's pulse. A `ref_pulse` and a `fb_pulse` in the same cycle raise neither request. `pump_up` and `pump_dn` are never high together.
- R6: With `pol_positive`=0 in detect mode, the values of `pump_up` and `pump_dn` are exchanged.
- R7: With `pin_release`=1 and `test_steer`=0, `pump_oe`, `pump_up` and `pump_dn` are all 0, and the detector's pending state is cleared. After release ends, neither request is high until a new input pulse arrives.
- R8: With `test_steer`=1 and `pin_release`=1, `pump_oe`=1 and `pump_dn`=0. `pump_up` follows `ref_pulse` in the same cycle when `pol_positive`=0, and follows `fb_pulse` in the same cycle when `pol_positive`=1.
- R9: The combination `test_steer`=1 with `pin_release`=0 is illegal. It releases the pin: `pump_oe`, `pump_up` and `pump_dn` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_pulse | input | 1 | Divided feedback event, one cycle wide |
| ratio | input | RATIO_W (10) | Requested division ratio |
| pin_release | input | 1 | Release the pump pin and idle the detector |
| pol_positive | input | 1 | 1: positive polarity; 0: negative (swap up/down). In test: selects feedback (1) or reference (0) |
| test_steer | input | 1 | Steer a raw divider output onto the pump pin |
| ref_pulse | output | 1 | Divided reference, one cycle per period |
| pump_up | output | 1 | Pump up request, or steered test signal |
| pump_dn | output | 1 | Pump down request |
| pump_oe | output | 1 | Pump pin drive enable (0 = high impedance) |
| ratio_err | output | 1 | Refused-ratio flag |

## Verification
On every cycle, the in-line assertions check the following:
- the divider's count stays below the accepted ratio;
- the accepted ratio never drops below 2 and changes only at terminal count;
- the divided pulse never lasts two cycles;
- the detector never holds both requests;
- a released pin carries no request, and test steering never drives the down line.

Some behaviour needs the bench's scenarios rather than per-cycle properties. These are the exact period length for each ratio across a sweep, the period in progress when a ratio changes mid-count, and the arithmetic of the refusal path. The bench scenarios also cover the timing of detector set and clear under reference-lead, feedback-lead and coincident pulses, the polarity swap, and which divider output is steered in test mode.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

   typedef enum logic [2:0] {
      MODE_DETECT   = 3'd0,
      MODE_RELEASED = 3'd1,
      MODE_TEST_REF = 3'd2,
      MODE_TEST_FB  = 3'd3,
      MODE_ILLEGAL  = 3'd4
   } pin_mode_e;

   function automatic pin_mode_e decode_mode(input logic test_en,
                                             input logic release_en,
                                             input logic pol_pos);
      pin_mode_e m;
      if (test_en) begin
         if (!release_en)  m = MODE_ILLEGAL;
         else if (pol_pos) m = MODE_TEST_FB;
         else              m = MODE_TEST_REF;
      end else begin
         m = release_en ? MODE_RELEASED : MODE_DETECT;
      end
      return m;
   endfunction

endpackage

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
   parameter int RATIO_W   = 10,
   parameter int MIN_RATIO = 2,
   parameter int DEF_RATIO = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RATIO_W-1:0] ratio_in,
   output logic               tc_pulse,
   output logic               ratio_err
);

   localparam logic [RATIO_W-1:0] MIN_V = RATIO_W'(MIN_RATIO);
   localparam logic [RATIO_W-1:0] DEF_V = RATIO_W'(DEF_RATIO);
   localparam logic [RATIO_W-1:0] ONE_V = RATIO_W'(1);

   logic [RATIO_W-1:0] active_q;
   logic [RATIO_W-1:0] count_q;
   logic               err_q;
   logic               at_tc;
   logic               req_ok;

   assign at_tc  = (count_q == '0);
   assign req_ok = (ratio_in >= MIN_V);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= DEF_V;
         count_q  <= DEF_V - ONE_V;
         err_q    <= 1'b0;
      end else begin
         err_q <= !req_ok;
         if (at_tc) begin
            if (req_ok) begin
               active_q <= ratio_in;
               count_q  <= ratio_in - ONE_V;
            end else begin
               count_q  <= active_q - ONE_V;
            end
         end else begin
            count_q <= count_q - ONE_V;
         end
      end
   end

   assign tc_pulse  = at_tc;
   assign ratio_err = err_q;

   assert_count_below_ratio_R1: assert property (@(posedge clk) disable iff (!rst_n)
      count_q < active_q);

   assert_single_cycle_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      at_tc |=> !at_tc);

   assert_active_ratio_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      active_q >= MIN_V);

   assert_ratio_change_at_tc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !at_tc |=> $stable(active_q));

endmodule

// File: rtl/refdiv_pfd.sv
module refdiv_pfd (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic ref_ev,
   input  logic fb_ev,
   output logic lead_ref,
   output logic lead_fb
);

   logic up_q, dn_q;
   logic up_n, dn_n;

   assign up_n = up_q | ref_ev;
   assign dn_n = dn_q | fb_ev;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else if (up_n && dn_n) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else begin
         up_q <= up_n;
         dn_q <= dn_n;
      end
   end

   assign lead_ref = up_q;
   assign lead_fb  = dn_q;

   assert_leads_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(up_q && dn_q));

   assert_ref_sets_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_ev && !fb_ev && !dn_q && !clear) |=> up_q);

   assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (!up_q && !dn_q));

endmodule

// File: rtl/refdiv_steer.sv
module refdiv_steer
   import refdiv_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  pin_mode_e mode,
   input  logic      lead_ref,
   input  logic      lead_fb,
   input  logic      ref_ev,
   input  logic      fb_ev,
   output logic      pump_up,
   output logic      pump_dn,
   output logic      pump_oe,
   input  logic      swap
);

   logic up_c, dn_c, oe_c;

   always_comb begin
      up_c = 1'b0;
      dn_c = 1'b0;
      oe_c = 1'b0;
      unique case (mode)
         MODE_DETECT: begin
            oe_c = 1'b1;
            up_c = swap ? lead_fb  : lead_ref;
            dn_c = swap ? lead_ref : lead_fb;
         end
         MODE_TEST_REF: begin
            oe_c = 1'b1;
            up_c = ref_ev;
         end
         MODE_TEST_FB: begin
            oe_c = 1'b1;
            up_c = fb_ev;
         end
         default: begin
            oe_c = 1'b0;
         end
      endcase
   end

   generate
      if (OUT_REG) begin : g_reg
         logic up_r, dn_r, oe_r;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               up_r <= 1'b0;
               dn_r <= 1'b0;
               oe_r <= 1'b0;
            end else begin
               up_r <= up_c;
               dn_r <= dn_c;
               oe_r <= oe_c;
            end
         end
         assign pump_up = up_r;
         assign pump_dn = dn_r;
         assign pump_oe = oe_r;
      end else begin : g_comb
         assign pump_up = up_c;
         assign pump_dn = dn_c;
         assign pump_oe = oe_c;

         assert_test_dn_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == MODE_TEST_REF || mode == MODE_TEST_FB) |-> (!pump_dn && pump_oe));

         assert_illegal_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == MODE_ILLEGAL) |-> !pump_oe);
      end
   endgenerate

   assert_released_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pump_oe |-> (!pump_up && !pump_dn));

endmodule

// File: rtl/refdiv_pfd_steer.sv
module refdiv_pfd_steer
   import refdiv_pkg::*;
#(
   parameter int RATIO_W   = 10,
   parameter int MIN_RATIO = 2,
   parameter int DEF_RATIO = 4,
   parameter bit OUT_REG   = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fb_pulse,
   input  logic [RATIO_W-1:0] ratio,
   input  logic               pin_release,
   input  logic               pol_positive,
   input  logic               test_steer,
   output logic               ref_pulse,
   output logic               pump_up,
   output logic               pump_dn,
   output logic               pump_oe,
   output logic               ratio_err
);

   localparam int MAX_RATIO = (1 << RATIO_W) - 1;

   initial begin
      assert (RATIO_W >= 2) else $error("RATIO_W must be at least 2");
      assert (MIN_RATIO >= 2) else $error("MIN_RATIO must be at least 2");
      assert (DEF_RATIO >= MIN_RATIO && DEF_RATIO <= MAX_RATIO)
         else $error("DEF_RATIO outside accepted range");
   end

   pin_mode_e mode;
   logic      tc;
   logic      lead_ref, lead_fb;
   logic      pfd_clear;

   assign mode      = decode_mode(test_steer, pin_release, pol_positive);
   assign pfd_clear = (mode != MODE_DETECT);

   refdiv_counter #(
      .RATIO_W  (RATIO_W),
      .MIN_RATIO(MIN_RATIO),
      .DEF_RATIO(DEF_RATIO)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .ratio_in (ratio),
      .tc_pulse (tc),
      .ratio_err(ratio_err)
   );

   refdiv_pfd u_pfd (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (pfd_clear),
      .ref_ev  (tc),
      .fb_ev   (fb_pulse),
      .lead_ref(lead_ref),
      .lead_fb (lead_fb)
   );

   refdiv_steer #(
      .OUT_REG(OUT_REG)
   ) u_steer (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .lead_ref(lead_ref),
      .lead_fb (lead_fb),
      .ref_ev  (tc),
      .fb_ev   (fb_pulse),
      .pump_up (pump_up),
      .pump_dn (pump_dn),
      .pump_oe (pump_oe),
      .swap    (!pol_positive)
   );

   assign ref_pulse = tc;

   assert_never_both_requests_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(pump_up && pump_dn));

endmodule

// File: tb/refdiv_pfd_steer_test.sv
module refdiv_pfd_steer_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       fb_pulse;
   logic [9:0] ratio;
   logic       pin_release, pol_positive, test_steer;
   logic       ref_pulse, pump_up, pump_dn, pump_oe, ratio_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   refdiv_pfd_steer uut (
      .clk(clk), .rst_n(rst_n), .fb_pulse(fb_pulse), .ratio(ratio),
      .pin_release(pin_release), .pol_positive(pol_positive), .test_steer(test_steer),
      .ref_pulse(ref_pulse), .pump_up(pump_up), .pump_dn(pump_dn),
      .pump_oe(pump_oe), .ratio_err(ratio_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wait_pulse;
      step;
      while (!ref_pulse) step;
   endtask

   task automatic measure(output int n);
      n = 0;
      do begin
         step;
         n++;
      end while (!ref_pulse);
   endtask

   int n;

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; fb_pulse = 1'b0; ratio = 10'd4;
      pin_release = 1'b0; pol_positive = 1'b1; test_steer = 1'b0;
      repeat (3) @(negedge clk);

      // R2: reset state
      chk(ref_pulse == 0, "R2 ref_pulse in reset", ref_pulse, 0);
      chk(pump_up == 0 && pump_dn == 0, "R2 requests in reset", {pump_up, pump_dn}, 0);
      chk(ratio_err == 0, "R2 ratio_err in reset", ratio_err, 0);
      chk(pump_oe == 1, "R2 pump_oe detect", pump_oe, 1);

      // R2: first pulse after third edge
      rst_n = 1'b1;
      step; chk(ref_pulse == 0, "R2 edge1", ref_pulse, 0);
      step; chk(ref_pulse == 0, "R2 edge2", ref_pulse, 0);
      step; chk(ref_pulse == 1, "R2 edge3", ref_pulse, 1);

      // R1: ratio sweep
      for (int r = 2; r <= 64; r++) begin
         ratio = 10'(r);
         measure(n);
         chk(n == r, "R1 period sweep", n, r);
      end
      ratio = 10'd1023; measure(n); chk(n == 1023, "R1 period max", n, 1023);
      ratio = 10'd512;  measure(n); chk(n == 512,  "R1 period 512", n, 512);
      ratio = 10'd2;    measure(n); chk(n == 2,    "R1 period min", n, 2);
      step; chk(ref_pulse == 0, "R1 single-cycle width", ref_pulse, 0);
      while (!ref_pulse) step;

      // R4: mid-period change
      ratio = 10'd10;
      n = 0;
      repeat (3) begin step; n++; end
      ratio = 10'd5;
      while (!ref_pulse) begin step; n++; end
      chk(n == 10, "R4 period in progress kept", n, 10);
      measure(n); chk(n == 5, "R4 new ratio next period", n, 5);

      // R3: refused ratios
      ratio = 10'd6; measure(n); chk(n == 6, "R3 baseline", n, 6);
      ratio = 10'd0;
      step; n = 1;
      chk(ratio_err == 1, "R3 err on 0", ratio_err, 1);
      while (!ref_pulse) begin step; n++; end
      chk(n == 6, "R3 ratio 0 holds previous", n, 6);
      measure(n); chk(n == 6, "R3 ratio 0 second period", n, 6);
      ratio = 10'd1; measure(n);
      chk(n == 6, "R3 ratio 1 holds previous", n, 6);
      chk(ratio_err == 1, "R3 err on 1", ratio_err, 1);
      ratio = 10'd3;
      step; n = 1;
      chk(ratio_err == 0, "R3 err clears", ratio_err, 0);
      while (!ref_pulse) begin step; n++; end
      chk(n == 3, "R3 valid after refusal", n, 3);

      // detector tests use a period of 20
      ratio = 10'd20; measure(n);
      pin_release = 1'b1; step; pin_release = 1'b0;
      chk(pump_up == 0 && pump_dn == 0, "R7 release clears state", {pump_up, pump_dn}, 0);

      // R5: reference leads
      wait_pulse;
      step; chk(pump_up == 1 && pump_dn == 0 && pump_oe == 1, "R5 ref lead up", {pump_up, pump_dn}, 2);
      step; step; chk(pump_up == 1, "R5 up held", pump_up, 1);
      fb_pulse = 1'b1; step; fb_pulse = 1'b0;
      chk(pump_up == 0 && pump_dn == 0, "R5 up cleared by fb", {pump_up, pump_dn}, 0);

      // R5: feedback leads
      step; fb_pulse = 1'b1; step; fb_pulse = 1'b0;
      chk(pump_dn == 1 && pump_up == 0, "R5 fb lead dn", {pump_up, pump_dn}, 1);
      while (!ref_pulse) step;
      chk(pump_dn == 1, "R5 dn held to ref", pump_dn, 1);
      step; chk(pump_up == 0 && pump_dn == 0, "R5 dn cleared by ref", {pump_up, pump_dn}, 0);

      // R5: coincident pulses
      wait_pulse;
      fb_pulse = 1'b1; step; fb_pulse = 1'b0;
      chk(pump_up == 0 && pump_dn == 0, "R5 coincident none", {pump_up, pump_dn}, 0);

      // R6: negative polarity swaps
      wait_pulse;
      pol_positive = 1'b0;
      step; chk(pump_dn == 1 && pump_up == 0, "R6 ref lead on dn", {pump_up, pump_dn}, 1);
      fb_pulse = 1'b1; step; fb_pulse = 1'b0;
      chk(pump_up == 0 && pump_dn == 0, "R6 cleared", {pump_up, pump_dn}, 0);
      step; fb_pulse = 1'b1; step; fb_pulse = 1'b0;
      chk(pump_up == 1 && pump_dn == 0, "R6 fb lead on up", {pump_up, pump_dn}, 2);
      wait_pulse; step;
      pol_positive = 1'b1;

      // R7: release mode
      wait_pulse; step;
      chk(pump_up == 1, "R7 pending before release", pump_up, 1);
      pin_release = 1'b1; #1;
      chk(pump_oe == 0 && pump_up == 0 && pump_dn == 0, "R7 released outputs",
          {pump_oe, pump_up, pump_dn}, 0);
      for (int k = 0; k < 25; k++) begin
         step;
         chk(pump_oe == 0 && pump_up == 0 && pump_dn == 0, "R7 released hold",
             {pump_oe, pump_up, pump_dn}, 0);
      end
      pin_release = 1'b0; #1;
      chk(pump_up == 0 && pump_dn == 0 && pump_oe == 1, "R7 no stale request",
          {pump_oe, pump_up, pump_dn}, 4);

      // R8: test steering of reference divider
      pin_release = 1'b1; test_steer = 1'b1; pol_positive = 1'b0;
      wait_pulse;
      for (int k = 0; k < 45; k++) begin
         chk(pump_up == ((k % 20) == 0), "R8 ref steered", pump_up, int'((k % 20) == 0));
         chk(pump_dn == 0 && pump_oe == 1, "R8 test dn/oe", {pump_oe, pump_dn}, 2);
         step;
      end

      // R8: test steering of feedback
      pol_positive = 1'b1;
      for (int k = 0; k < 16; k++) begin
         fb_pulse = ((k % 3) == 0); #1;
         chk(pump_up == fb_pulse, "R8 fb steered", pump_up, fb_pulse);
         chk(pump_dn == 0 && pump_oe == 1, "R8 fb dn/oe", {pump_oe, pump_dn}, 2);
         step;
      end
      fb_pulse = 1'b0;

      // R9: illegal combination
      pin_release = 1'b0;
      for (int k = 0; k < 25; k++) begin
         fb_pulse = k[0]; #1;
         chk(pump_oe == 0 && pump_up == 0 && pump_dn == 0, "R9 illegal released",
             {pump_oe, pump_up, pump_dn}, 0);
         step;
      end
      fb_pulse = 1'b0;
      test_steer = 1'b0;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule